// File: doc/BRIEF.md
# USB Host IN Endpoint Controller

This block holds the control and status state for one receive endpoint of a USB host. Software sets a request bit to start an IN transaction. The block offers that request to a transaction scheduler through a request/grant handshake, together with the target device's function address and, for devices behind a hub, the hub address and hub port. When the scheduler reports that a packet has landed in the receive FIFO, the block marks the endpoint ready and raises a sticky interrupt.

Unloading is tracked with a per-byte read strobe from the FIFO read side. Software or DMA may release a packet explicitly. In auto-clear mode, a packet of exactly the maximum size releases itself when its last byte is read. In auto-request mode, the endpoint going empty re-arms the request bit. Used together, the two modes give hands-free bulk reception. An optional double-buffer mode lets two packets wait at once.

Register map (address on `reg_addr`):
- 0, control: write bit 0 = 1 sets the request, write bit 1 = 1 releases the oldest packet, bits 2/3/4 store auto-clear, auto-request and double-buffer enables. Read: bit 0 request, bit 1 ready, bits 2..4 enables, bits 6:5 packets pending, bits 26:16 byte count of the oldest packet.
- 1: maximum packet size in bits 10:0.
- 2: target, with function address in bits 6:0, hub address in bits 14:8 and hub port in bits 22:16.
- 3: interrupt status in bit 0. A read of this address clears it.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, `sched_req`, `rx_ready` and `rx_irq` are 0, the control register reads 0 and the maximum packet size reads 64.
- R2: Writing 1 to control bit 0 raises `sched_req` on the next cycle. The target register fields drive `sched_func_addr`, `sched_hub_addr` and `sched_hub_port`.
- R3: A cycle with both `sched_grant` and `sched_req` high drops `sched_req` on the next cycle.
- R4: A request write is ignored while every enabled buffer holds a packet: one buffer normally, two in double-buffer mode.
- R5: A `pkt_rx_valid` strobe that finds a free buffer sets `rx_ready` on the next cycle. The stored `pkt_rx_bytes` value reads back in control bits 26:16.
- R6: Writing 1 to control bit 1 releases the oldest packet. `rx_ready` falls once no packet is left.
- R7: With auto-clear on, a packet whose byte count equals the maximum packet size is released on the cycle its last byte is read through `fifo_rd`.
- R8: A packet shorter than the maximum size is not released by auto-clear. `rx_ready` stays 1 after all of its bytes are read.
- R9: With auto-request on, the cycle in which `rx_ready` falls also sets the request bit.
- R10: In double-buffer mode, two packets are held. `rx_ready` stays 1 until both are released, and they are released oldest first. A packet arriving when all buffers are full is dropped.
- R11: The interrupt is sticky. It is set by every accepted packet and cleared by a read of address 3; when both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sched_req | output | 1 | Active IN transaction request to the scheduler |
| sched_grant | input | 1 | Scheduler accepts the request |
| sched_func_addr | output | 7 | Target device function address |
| sched_hub_addr | output | 7 | Hub address for the target |
| sched_hub_port | output | 7 | Hub port for the target |
| pkt_rx_valid | input | 1 | Strobe: a packet was written to the receive FIFO |
| pkt_rx_bytes | input | 11 | Byte count of that packet |
| fifo_rd | input | 1 | One byte unloaded from the oldest packet |
| rx_ready | output | 1 | At least one received packet is waiting |
| rx_irq | output | 1 | Sticky receive interrupt |

## Verification
All state is registered. A register write, grant, packet strobe or final `fifo_rd` shows its effect at the ports one clock edge later, while `reg_rdata` follows `reg_addr` within the same cycle. The bench drives every input on a falling edge and removes it on the next falling edge, so exactly one rising edge falls in between. Results are then sampled on that second falling edge, with register reads taken one time unit after the address settles. Auto-clear is checked at the strobe of the final byte, with a check one byte earlier confirming that the packet is still held.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int CNT_W   = 11;
    localparam int DEV_W   = 7;
    localparam int SLOTS   = 2;
    localparam int PTR_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int PEND_W  = $clog2(SLOTS + 1);

    // control register bit positions
    localparam int CB_REQ   = 0;
    localparam int CB_CLR   = 1;
    localparam int CB_ACLR  = 2;
    localparam int CB_AREQ  = 3;
    localparam int CB_DBL   = 4;
    localparam int CB_PEND  = 5;
    localparam int CB_COUNT = 16;

    // target register field positions
    localparam int TF_FUNC = 0;
    localparam int TF_HUB  = 8;
    localparam int TF_PORT = 16;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_MAXP   = 2'd1,
        RA_TARGET = 2'd2,
        RA_INT    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              dbl;
        logic              auto_req;
        logic              auto_clr;
        logic [CNT_W-1:0]  maxp;
        logic [DEV_W-1:0]  func;
        logic [DEV_W-1:0]  hub_addr;
        logic [DEV_W-1:0]  hub_port;
    } ep_cfg_t;

    typedef struct packed {
        logic              req;
        logic [PEND_W-1:0] pending;
        logic [CNT_W-1:0]  head_bytes;
    } ep_stat_t;

    function automatic logic [PEND_W-1:0] slot_cap(input logic dbl);
        return dbl ? PEND_W'(SLOTS) : PEND_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : PTR_W'(p + PTR_W'(1));
    endfunction

endpackage

// File: rtl/usb_in_ep_rxq.sv
module usb_in_ep_rxq
    import usb_in_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbl,
    input  logic              auto_clr,
    input  logic [CNT_W-1:0]  maxp,
    input  logic              pkt_valid,
    input  logic [CNT_W-1:0]  pkt_bytes,
    input  logic              fifo_rd,
    input  logic              sw_clr,
    output logic [PEND_W-1:0] pending,
    output logic [CNT_W-1:0]  head_bytes,
    output logic              pkt_accept,
    output logic              ready_fall,
    output logic              full
);
    logic [CNT_W-1:0] slot_bytes [SLOTS];
    logic [PTR_W-1:0] head_ptr, tail_ptr;
    logic [CNT_W-1:0] rd_cnt;
    logic             have, auto_pop, pop;

    always_comb begin
        full       = (pending >= slot_cap(dbl));
        pkt_accept = pkt_valid && !full;
        have       = (pending != '0);
        head_bytes = slot_bytes[head_ptr];
        auto_pop   = auto_clr && have && fifo_rd && (head_bytes == maxp)
                     && ((rd_cnt + CNT_W'(1)) == maxp);
        pop        = have && (sw_clr || auto_pop);
        ready_fall = pop && (pending == PEND_W'(1)) && !pkt_accept;
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_bytes[i] <= '0;
            else if (pkt_accept && (tail_ptr == PTR_W'(i)))
                slot_bytes[i] <= pkt_bytes;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= '0;
            head_ptr <= '0;
            tail_ptr <= '0;
            rd_cnt   <= '0;
        end else begin
            pending <= PEND_W'(pending + PEND_W'(pkt_accept) - PEND_W'(pop));
            if (pkt_accept) tail_ptr <= ptr_next(tail_ptr);
            if (pop)        head_ptr <= ptr_next(head_ptr);
            if (pop)
                rd_cnt <= '0;
            else if (fifo_rd && have && (rd_cnt != head_bytes))
                rd_cnt <= rd_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/usb_in_ep_req.sv
module usb_in_ep_req (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic grant,
    input  logic auto_req,
    input  logic ready_fall,
    input  logic full,
    output logic req_q
);
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else if (grant && req_q)
            req_q <= 1'b0;
        else if ((set_req && !full) || (auto_req && ready_fall))
            req_q <= 1'b1;
    end
endmodule

// File: rtl/usb_in_ep_regs.sv
module usb_in_ep_regs
    import usb_in_ep_pkg::*;
#(
    parameter logic [CNT_W-1:0] MAXP_RST = CNT_W'(64)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  ep_stat_t          stat,
    input  logic              pkt_accept,
    output ep_cfg_t           cfg,
    output logic              set_req,
    output logic              sw_clr,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);
    reg_addr_e ra;
    assign ra = reg_addr_e'(addr);

    assign set_req = wr && (ra == RA_CTRL) && wdata[CB_REQ];
    assign sw_clr  = wr && (ra == RA_CTRL) && wdata[CB_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cfg.maxp <= MAXP_RST;
        end else if (wr) begin
            case (ra)
                RA_CTRL: begin
                    cfg.auto_clr <= wdata[CB_ACLR];
                    cfg.auto_req <= wdata[CB_AREQ];
                    cfg.dbl      <= wdata[CB_DBL];
                end
                RA_MAXP:   cfg.maxp <= wdata[CNT_W-1:0];
                RA_TARGET: begin
                    cfg.func     <= wdata[TF_FUNC +: DEV_W];
                    cfg.hub_addr <= wdata[TF_HUB  +: DEV_W];
                    cfg.hub_port <= wdata[TF_PORT +: DEV_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (pkt_accept)
            irq <= 1'b1;
        else if (rd && (ra == RA_INT))
            irq <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (ra)
            RA_CTRL: begin
                rdata[CB_REQ]                 = stat.req;
                rdata[CB_CLR]                 = (stat.pending != '0);
                rdata[CB_ACLR]                = cfg.auto_clr;
                rdata[CB_AREQ]                = cfg.auto_req;
                rdata[CB_DBL]                 = cfg.dbl;
                rdata[CB_PEND +: PEND_W]      = stat.pending;
                rdata[CB_COUNT +: CNT_W]      = stat.head_bytes;
            end
            RA_MAXP:   rdata[CNT_W-1:0] = cfg.maxp;
            RA_TARGET: begin
                rdata[TF_FUNC +: DEV_W] = cfg.func;
                rdata[TF_HUB  +: DEV_W] = cfg.hub_addr;
                rdata[TF_PORT +: DEV_W] = cfg.hub_port;
            end
            RA_INT:    rdata[0] = irq;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter logic [CNT_W-1:0] MAXP_RST = CNT_W'(64)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sched_req,
    input  logic              sched_grant,
    output logic [DEV_W-1:0]  sched_func_addr,
    output logic [DEV_W-1:0]  sched_hub_addr,
    output logic [DEV_W-1:0]  sched_hub_port,
    input  logic              pkt_rx_valid,
    input  logic [CNT_W-1:0]  pkt_rx_bytes,
    input  logic              fifo_rd,
    output logic              rx_ready,
    output logic              rx_irq
);
    ep_cfg_t           cfg;
    ep_stat_t          stat;
    logic              set_req, sw_clr, pkt_accept, ready_fall, full, req_q;
    logic [PEND_W-1:0] pending;
    logic [CNT_W-1:0]  head_bytes;

    usb_in_ep_regs #(.MAXP_RST(MAXP_RST)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .stat(stat), .pkt_accept(pkt_accept), .cfg(cfg),
        .set_req(set_req), .sw_clr(sw_clr), .irq(rx_irq), .rdata(reg_rdata)
    );

    usb_in_ep_rxq u_rxq (
        .clk(clk), .rst(rst), .dbl(cfg.dbl), .auto_clr(cfg.auto_clr),
        .maxp(cfg.maxp), .pkt_valid(pkt_rx_valid), .pkt_bytes(pkt_rx_bytes),
        .fifo_rd(fifo_rd), .sw_clr(sw_clr), .pending(pending),
        .head_bytes(head_bytes), .pkt_accept(pkt_accept),
        .ready_fall(ready_fall), .full(full)
    );

    usb_in_ep_req u_req (
        .clk(clk), .rst(rst), .set_req(set_req), .grant(sched_grant),
        .auto_req(cfg.auto_req), .ready_fall(ready_fall), .full(full),
        .req_q(req_q)
    );

    always_comb begin
        stat.req        = req_q;
        stat.pending    = pending;
        stat.head_bytes = head_bytes;
    end

    assign sched_req       = req_q;
    assign sched_func_addr = cfg.func;
    assign sched_hub_addr  = cfg.hub_addr;
    assign sched_hub_port  = cfg.hub_port;
    assign rx_ready        = (pending != '0);
endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk
    import usb_in_ep_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              sched_req,
    input logic              sched_grant,
    input logic              pkt_rx_valid,
    input logic              rx_ready,
    input logic              rx_irq,
    input logic [PEND_W-1:0] pending
);
    a_r3_grant_drops_req: assert property (@(posedge clk) disable iff (rst)
        sched_req && sched_grant |=> !sched_req);

    a_r5_ready_follows_pkt: assert property (@(posedge clk) disable iff (rst)
        pkt_rx_valid && !rx_ready |=> rx_ready);

    a_r11_irq_follows_pkt: assert property (@(posedge clk) disable iff (rst)
        pkt_rx_valid && !rx_ready |=> rx_irq);

    a_r6_ready_rise_has_pkt: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(pkt_rx_valid));

    a_r9_req_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(sched_req) |-> ($past(reg_wr) || $fell(rx_ready)));

    a_r10_pending_bound: assert property (@(posedge clk) disable iff (rst)
        pending <= PEND_W'(SLOTS));
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .sched_req(sched_req),
    .sched_grant(sched_grant), .pkt_rx_valid(pkt_rx_valid),
    .rx_ready(rx_ready), .rx_irq(rx_irq), .pending(pending)
);

// File: tb/usb_in_ep_ctrl_tb.sv
module usb_in_ep_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sched_req, sched_grant = 1'b0;
    logic [6:0]  sched_func_addr, sched_hub_addr, sched_hub_port;
    logic        pkt_rx_valid = 1'b0;
    logic [10:0] pkt_rx_bytes = '0;
    logic        fifo_rd = 1'b0;
    logic        rx_ready, rx_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    usb_in_ep_ctrl u_dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pkt(input int n);
        @(negedge clk); pkt_rx_valid = 1'b1; pkt_rx_bytes = 11'(n);
        @(negedge clk); pkt_rx_valid = 1'b0;
    endtask

    task automatic pull(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fifo_rd = 1'b1;
        end
        @(negedge clk); fifo_rd = 1'b0;
    endtask

    task automatic grant1;
        @(negedge clk); sched_grant = 1'b1;
        @(negedge clk); sched_grant = 1'b0;
    endtask

    function automatic bit exp_ready(input int len, input int maxp, input bit aclr);
        return !(aclr && (len == maxp));
    endfunction

    function automatic int f_pend(input logic [31:0] d); return int'(d[6:5]);   endfunction
    function automatic int f_head(input logic [31:0] d); return int'(d[26:16]); endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check(!sched_req && !rx_ready && !rx_irq, "R1 outputs", {sched_req, rx_ready, rx_irq}, 0);
        rd(2'd0, d); check(d == 0, "R1 ctrl", d, 0);
        rd(2'd1, d); check(d == 64, "R1 maxp", d, 64);

        // R2 target and request
        wr(2'd2, (32'd3 << 16) | (32'd9 << 8) | 32'd5);
        check(sched_func_addr == 5 && sched_hub_addr == 9 && sched_hub_port == 3, "R2 target",
              {sched_func_addr, sched_hub_addr, sched_hub_port}, 5 << 14 | 9 << 7 | 3);
        wr(2'd0, 32'h1);
        check(sched_req == 1, "R2 req", sched_req, 1);
        // R3 grant clears
        grant1();
        check(sched_req == 0, "R3 grant", sched_req, 0);

        // R5 packet lands
        pkt(20);
        check(rx_ready && rx_irq, "R5 ready", {rx_ready, rx_irq}, 3);
        rd(2'd0, d); check(f_head(d) == 20, "R5 count", f_head(d), 20);
        // R4 request blocked while full
        wr(2'd0, 32'h1);
        check(sched_req == 0, "R4 blocked", sched_req, 0);
        // R10 drop when full
        pkt(30);
        rd(2'd0, d);
        check(f_pend(d) == 1 && f_head(d) == 20, "R10 drop", f_head(d), 20);

        // R11 sticky clear on read
        rd(2'd3, d); check(d[0] == 1, "R11 read", d[0], 1);
        check(rx_irq == 0, "R11 cleared", rx_irq, 0);

        // R6 manual release
        wr(2'd0, 32'h2);
        check(rx_ready == 0, "R6 release", rx_ready, 0);

        // R7 auto-clear on max-sized packet
        wr(2'd0, 32'h4);
        wr(2'd1, 32'd8);
        pkt(8);
        pull(7);
        check(rx_ready == 1, "R7 held before last", rx_ready, 1);
        pull(1);
        check(rx_ready == 0, "R7 auto clear", rx_ready, 0);

        // R8 short packet stays
        pkt(5);
        pull(5);
        check(rx_ready == 1, "R8 short stays", rx_ready, 1);
        wr(2'd0, 32'h6);
        check(rx_ready == 0, "R6 release short", rx_ready, 0);

        // R9 auto re-request
        wr(2'd0, 32'hC);
        pkt(8);
        pull(8);
        check(rx_ready == 0 && sched_req == 1, "R9 rearm", {rx_ready, sched_req}, 1);
        grant1();

        // R10 double buffering
        wr(2'd0, 32'h10);
        pkt(4);
        pkt(6);
        rd(2'd0, d);
        check(f_pend(d) == 2 && f_head(d) == 4, "R10 two pending", f_head(d), 4);
        wr(2'd0, 32'h11);
        check(sched_req == 0, "R4 blocked dbl", sched_req, 0);
        wr(2'd0, 32'h12);
        rd(2'd0, d);
        check(rx_ready == 1 && f_head(d) == 6, "R10 second head", f_head(d), 6);
        wr(2'd0, 32'h12);
        check(rx_ready == 0, "R10 both released", rx_ready, 0);

        // R11 set wins over read-clear
        rd(2'd3, d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3; pkt_rx_valid = 1'b1; pkt_rx_bytes = 11'd3;
        @(negedge clk); reg_rd = 1'b0; pkt_rx_valid = 1'b0;
        check(rx_irq == 1, "R11 set wins", rx_irq, 1);
        wr(2'd0, 32'h12);
        wr(2'd0, 32'h10);
        rd(2'd3, d);

        // random R7/R8 mix
        wr(2'd0, 32'h4);
        wr(2'd1, 32'd16);
        for (int k = 0; k < 24; k++) begin
            int len;
            len = ($urandom_range(0, 1) == 1) ? 16 : int'($urandom_range(1, 16));
            pkt(len);
            rd(2'd0, d);
            check(f_head(d) == len, "R5 random count", f_head(d), len);
            pull(len);
            check(rx_ready == exp_ready(len, 16, 1'b1), len == 16 ? "R7 random" : "R8 random",
                  rx_ready, exp_ready(len, 16, 1'b1));
            if (rx_ready) wr(2'd0, 32'h6);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule